// File: doc/BRIEF.md
# Audio Frame Sequencer

This block turns the audio system clock into a slow step rate and steps through an eight-entry schedule. Each step can raise single-cycle strobes for three kinds of downstream timing:

- length counters, 256 Hz;
- the frequency sweep unit, 128 Hz;
- the volume envelopes, 64 Hz.

With the default period of 8192 clocks, a 4,194,304 Hz clock gives 512 steps per second. A non-zero value on `div_override` replaces that period while the block runs, which is used to change tempo or to shorten runs in simulation. The `STEP_CLKS` parameter sets the default period.

The schedule is held in a small state machine with nine states:

- `FS_OFF`: power is off.
- `FS_P0` to `FS_P7`: one state per phase.

It has these transitions:

- Any state goes to `FS_OFF` when power is low.
- `FS_OFF` goes to `FS_P0` on the first powered edge with no step.
- `FS_OFF` goes to `FS_P1` on a powered edge that is also a step.
- `FS_Pk` goes to `FS_P(k+1)` on a step.
- `FS_P7` goes to `FS_P0` on a step.
- Any powered state holds when there is no step.

While power is low, the divider and the phase are held cleared. Switching power back on therefore always restarts the schedule at phase 0 with a full period.

Top module: `audio_frame_seq`

## Requirements
- R1: While `rst_n` is low, `phase` is 0 and all three strobes are low. The same values hold at the first sample after reset is released.
- R2: With `div_override` at 0, the step period is `STEP_CLKS` clocks. The first step happens on the `STEP_CLKS`-th rising edge, counting the first edge at which `pwr_en` is sampled high as the first. Later steps follow every `STEP_CLKS` edges.
- R3: A non-zero `div_override` sets the period to its own value in clocks. A value of 1 makes every powered edge a step. The counter is compared with greater-or-equal, so a shortened period takes effect at once.
- R4: `phase` is the binary index 0 to 7 of the next step to execute. It advances by one on each step edge and wraps from 7 to 0.
- R5: `len_stb` is high after a step executed from phase 0, 2, 4 or 6.
- R6: `sweep_stb` is high after a step executed from phase 2 or 6.
- R7: `env_stb` is high only after a step executed from phase 7.
- R8: Strobes are registered on the step edge, together with the phase update. They decode the phase held before that edge and last exactly one clock. Between steps, all strobes are low.
- R9: When `pwr_en` is sampled low, the next state has `phase` at 0, the divider cleared and no strobe. When power returns, the first step comes a full period later and executes phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_en | input | 1 | Power-enable level; low holds the sequencer cleared |
| div_override | input | DIV_W | Step period in clocks; 0 selects `STEP_CLKS` |
| len_stb | output | 1 | Length-counter clock strobe |
| sweep_stb | output | 1 | Frequency-sweep clock strobe |
| env_stb | output | 1 | Envelope clock strobe |
| phase | output | 3 | Index of the next step to execute |

## Verification
The bench walks two full laps of the schedule. A decoder keyed to the wrong phase, or keyed to the phase after the edge instead of before it, shows up as strobes on odd steps or one step late. It cuts power in the middle of a lap and checks that the phase returns to 0 and that the next step after power returns is phase 0 at a full period; a design that only froze the phase would resume at phase 3 or step early. It then shortens the period, down to a step on every edge. A divider compared with equality would miss the new limit, and a strobe stretched over two cycles would appear on back-to-back steps where it must not.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [3:0] {
        FS_OFF,
        FS_P0,
        FS_P1,
        FS_P2,
        FS_P3,
        FS_P4,
        FS_P5,
        FS_P6,
        FS_P7
    } fs_state_t;

    localparam int NUM_PHASES = 8;
    localparam int PHASE_W    = $clog2(NUM_PHASES);

    function automatic logic [PHASE_W-1:0] phase_of(fs_state_t s);
        logic [PHASE_W-1:0] idx;
        unique case (s)
            FS_OFF:  idx = 3'd0;
            FS_P0:   idx = 3'd0;
            FS_P1:   idx = 3'd1;
            FS_P2:   idx = 3'd2;
            FS_P3:   idx = 3'd3;
            FS_P4:   idx = 3'd4;
            FS_P5:   idx = 3'd5;
            FS_P6:   idx = 3'd6;
            FS_P7:   idx = 3'd7;
            default: idx = 3'd0;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/fseq_divider.sv
module fseq_divider #(
    parameter  int STEP_CLKS = 8192,
    localparam int DIV_W     = $clog2(STEP_CLKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_en,
    input  logic [DIV_W-1:0] div_override,
    output logic             tick
);
    localparam logic [DIV_W-1:0] DEF_PERIOD = DIV_W'(STEP_CLKS);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    always_comb begin
        if (div_override != '0) begin
            limit = div_override - 1'b1;
        end else begin
            limit = DEF_PERIOD - 1'b1;
        end
        tick = pwr_en && (cnt >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!pwr_en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fseq_phase_fsm.sv
module fseq_phase_fsm
    import fseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pwr_en,
    input  logic      tick,
    output fs_state_t state
);
    fs_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            FS_OFF: nxt = tick ? FS_P1 : FS_P0;
            FS_P0:  nxt = tick ? FS_P1 : FS_P0;
            FS_P1:  nxt = tick ? FS_P2 : FS_P1;
            FS_P2:  nxt = tick ? FS_P3 : FS_P2;
            FS_P3:  nxt = tick ? FS_P4 : FS_P3;
            FS_P4:  nxt = tick ? FS_P5 : FS_P4;
            FS_P5:  nxt = tick ? FS_P6 : FS_P5;
            FS_P6:  nxt = tick ? FS_P7 : FS_P6;
            FS_P7:  nxt = tick ? FS_P0 : FS_P7;
            default: nxt = FS_OFF;
        endcase
        if (!pwr_en) begin
            nxt = FS_OFF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FS_OFF;
        end else begin
            state <= nxt;
        end
    end
endmodule

// File: rtl/fseq_strobe_gen.sv
module fseq_strobe_gen
    import fseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  fs_state_t state,
    output logic      len_stb,
    output logic      sweep_stb,
    output logic      env_stb
);
    logic d_len, d_sweep, d_env;

    always_comb begin
        d_len   = 1'b0;
        d_sweep = 1'b0;
        d_env   = 1'b0;
        unique case (state)
            FS_OFF, FS_P0, FS_P4: d_len = 1'b1;
            FS_P2, FS_P6: begin
                d_len   = 1'b1;
                d_sweep = 1'b1;
            end
            FS_P7: d_env = 1'b1;
            FS_P1, FS_P3, FS_P5: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_stb   <= 1'b0;
            sweep_stb <= 1'b0;
            env_stb   <= 1'b0;
        end else begin
            len_stb   <= tick && d_len;
            sweep_stb <= tick && d_sweep;
            env_stb   <= tick && d_env;
        end
    end
endmodule

// File: rtl/audio_frame_seq.sv
module audio_frame_seq
    import fseq_pkg::*;
#(
    parameter  int STEP_CLKS = 8192,
    localparam int DIV_W     = $clog2(STEP_CLKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_en,
    input  logic [DIV_W-1:0] div_override,
    output logic             len_stb,
    output logic             sweep_stb,
    output logic             env_stb,
    output logic [2:0]       phase
);
    logic      tick;
    fs_state_t state;

    fseq_divider #(.STEP_CLKS(STEP_CLKS)) u_div (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_en       (pwr_en),
        .div_override (div_override),
        .tick         (tick)
    );

    fseq_phase_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_en (pwr_en),
        .tick   (tick),
        .state  (state)
    );

    fseq_strobe_gen u_stb (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .state     (state),
        .len_stb   (len_stb),
        .sweep_stb (sweep_stb),
        .env_stb   (env_stb)
    );

    assign phase = phase_of(state);
endmodule

// File: rtl/audio_frame_seq_chk.sv
module audio_frame_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_en,
    input logic       len_stb,
    input logic       sweep_stb,
    input logic       env_stb,
    input logic [2:0] phase
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (phase == 3'd0 && !len_stb && !sweep_stb && !env_stb)); // R1

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && $past(pwr_en) && phase != $past(phase)) |-> phase == $past(phase) + 3'd1); // R4

    AST_LEN_FROM_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        len_stb |-> phase[0]); // R5

    AST_SWEEP_WITH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_stb |-> (len_stb && (phase == 3'd3 || phase == 3'd7))); // R6

    AST_ENV_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        env_stb |-> (phase == 3'd0 && !len_stb)); // R7

    AST_LEN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        len_stb |=> !len_stb); // R8

    AST_ENV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        env_stb |=> !env_stb); // R8

    AST_POWER_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |=> (phase == 3'd0 && !len_stb && !sweep_stb && !env_stb)); // R9
endmodule

bind audio_frame_seq audio_frame_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_en    (pwr_en),
    .len_stb   (len_stb),
    .sweep_stb (sweep_stb),
    .env_stb   (env_stb),
    .phase     (phase)
);

// File: tb/tb_audio_frame_seq.sv
module tb_audio_frame_seq;
    localparam int P     = 6;
    localparam int DIV_W = $clog2(P + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pwr_en = 1'b0;
    logic [DIV_W-1:0] div_override = '0;
    logic             len_stb, sweep_stb, env_stb;
    logic [2:0]       phase;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    audio_frame_seq #(.STEP_CLKS(P)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_en       (pwr_en),
        .div_override (div_override),
        .len_stb      (len_stb),
        .sweep_stb    (sweep_stb),
        .env_stb      (env_stb),
        .phase        (phase)
    );

    // {len, sweep, env, phase after step}, one entry per step starting at phase 0
    localparam logic [5:0] VEC [16] = '{
        6'b100_001, 6'b000_010, 6'b110_011, 6'b000_100,
        6'b100_101, 6'b000_110, 6'b110_111, 6'b001_000,
        6'b100_001, 6'b000_010, 6'b110_011, 6'b000_100,
        6'b100_101, 6'b000_110, 6'b110_111, 6'b001_000
    };

    function automatic logic [5:0] obs();
        return {len_stb, sweep_stb, env_stb, phase};
    endfunction

    task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // waits n negedges; returns 1 if any strobe appeared before the last one
    task automatic run_quiet(input int n, output bit noisy);
        noisy = 1'b0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (i < n && (len_stb || sweep_stb || env_stb)) noisy = 1'b1;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        bit noisy;
        repeat (3) @(negedge clk);
        chk("R1 in reset", obs(), 6'b000_000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", obs(), 6'b000_000);

        // table walk: R2 R4 R5 R6 R7 R8
        pwr_en = 1'b1;
        for (int k = 0; k < 19; k++) begin
            run_quiet(P, noisy);
            chk("R2/R8 quiet between steps", {5'd0, noisy}, 6'd0);
            chk("R4/R5/R6/R7 step vector", obs(), VEC[k % 16]);
        end
        @(negedge clk);
        chk("R8 strobe one cycle", obs(), 6'b000_011);

        // power off at phase 3: R9
        pwr_en = 1'b0;
        @(negedge clk);
        chk("R9 phase cleared", obs(), 6'b000_000);
        run_quiet(2 * P, noisy);
        chk("R9 no strobes while off", {5'd0, noisy | len_stb | sweep_stb | env_stb}, 6'd0);

        pwr_en = 1'b1;
        run_quiet(P, noisy);
        chk("R9 quiet full period after power on", {5'd0, noisy}, 6'd0);
        chk("R9/R2 first step is phase 0", obs(), 6'b100_001);

        // override period 3: R3
        div_override = DIV_W'(3);
        run_quiet(3, noisy);
        chk("R3 quiet", {5'd0, noisy}, 6'd0);
        chk("R3 override 3 step", obs(), 6'b000_010);
        run_quiet(3, noisy);
        chk("R3/R6 override 3 sweep step", obs(), 6'b110_011);

        // override period 1: step every edge, R3 R7 R4 wrap
        div_override = DIV_W'(1);
        @(negedge clk); chk("R3 every edge p3", obs(), 6'b000_100);
        @(negedge clk); chk("R3/R5 every edge p4", obs(), 6'b100_101);
        @(negedge clk); chk("R3 every edge p5", obs(), 6'b000_110);
        @(negedge clk); chk("R3/R6 every edge p6", obs(), 6'b110_111);
        @(negedge clk); chk("R7/R4 wrap p7", obs(), 6'b001_000);

        // power-off from override mode, then power-on immediate step with period 1
        pwr_en = 1'b0;
        @(negedge clk);
        chk("R9 clear under override", obs(), 6'b000_000);
        pwr_en = 1'b1;
        @(negedge clk);
        chk("R9/R3 first step after power on", obs(), 6'b100_001);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule